// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block sends a stereo pair of 18-bit audio samples out on a single serial data line. It does not make its own bit clock or frame clock. Both come from outside and are sampled by a faster system clock. The block sets its output in response to each falling edge of the bit clock, so the receiver can capture every bit on the next rising edge.

Each channel takes one half of a frame. A channel sends 18 bits, most significant bit first, and then drives zeros until the frame clock changes level again. A static format input picks one of two framings:

- **Left-justified:** the first bit goes out at the frame-clock transition, and a high frame clock marks the left channel.
- **I2S-compatible:** the first bit comes one bit period later, and a low frame clock marks the left channel.

A host writes a new left/right pair with a load strobe. The pair waits in a staging register until the next left-channel start, so a write in the middle of a frame never changes a channel that is already being sent.

Top module: `dual_fmt_audio_tx`

## Requirements
- R1: Each channel word is 18 bits wide and is sent most significant bit first, one bit per bit-clock period.
- R2: With `fmt_i2s`=0 (left-justified), bit 17 appears on the falling bit-clock edge where the frame clock has changed level. Bits 16..0 follow on the next 17 falling edges.
- R3: With `fmt_i2s`=1 (I2S), the output is 0 on the falling edge where the frame clock changed level. Bit 17 appears on the next falling edge, and bits 16..0 follow on the 17 falling edges after that.
- R4: Channel selection depends on the format. When `fmt_i2s`=0, `lrck`=1 selects the left word and `lrck`=0 selects the right word. When `fmt_i2s`=1, `lrck`=0 selects the left word and `lrck`=1 selects the right word.
- R5: After a channel's last bit, `sdata` is 0 for every remaining bit period until the next frame-clock level change.
- R6: `sdata` changes only in the system-clock cycle that follows a sampled falling edge of `bclk`. It holds its value through the whole high phase of `bclk`.
- R7: A pair written with `ld_stb` takes effect at the next left-channel start. A write during a frame changes neither channel of that frame, and both channels of the next frame use it.
- R8: A half-frame may contain any number of bit periods, for example 24 or 40. The block always sends 18 bits and pads with zeros up to the next frame-clock edge.
- R9: After reset `sdata` is 0. The first falling bit-clock edge only records the frame-clock level, and nothing is sent before the first frame-clock change seen after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame (channel) clock |
| fmt_i2s | input | 1 | Static format: 0 left-justified, 1 I2S |
| ld_stb | input | 1 | One-cycle strobe that writes a new sample pair |
| ld_left | input | 18 | Left sample word |
| ld_right | input | 18 | Right sample word |
| sdata | output | 1 | Serial data out |

## Verification
The assertions check the following properties on every cycle:
- The output moves only after a sampled falling edge of the bit clock.
- The shift count never goes past 18.
- Padding stays at zero once the word has been sent.
- At a frame edge, the left-justified mode launches the word's top bit and the I2S mode outputs an empty slot.

Other behaviours need whole scenarios run by the bench, because they depend on values across a full frame:
- that the bit order on the line matches the loaded words;
- that the left and right words are placed correctly for each frame-clock polarity;
- that a write in the middle of a frame is held back until the next frame;
- that half-frames longer or shorter than 32 bit periods are handled correctly.

// File: rtl/dual_fmt_audio_tx.sv
module dual_fmt_audio_tx #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         lrck,
  input  logic         fmt_i2s,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_left,
  input  logic [W-1:0] ld_right,
  output logic         sdata
);
  localparam int CW = $clog2(W + 1);

  logic         bclk_q, lr_last, armed;
  logic [W-1:0] stage_l, stage_r, hold_r, sh;
  logic [CW-1:0] rem;

  wire         fall       = bclk_q & ~bclk;
  wire         lr_edge    = fall & armed & (lrck != lr_last);
  wire         start_left = lr_edge & (lrck ^ fmt_i2s);
  wire [W-1:0] word       = start_left ? stage_l : hold_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      lr_last <= 1'b0;
      armed   <= 1'b0;
      stage_l <= '0;
      stage_r <= '0;
      hold_r  <= '0;
      sh      <= '0;
      rem     <= '0;
      sdata   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (ld_stb) begin
        stage_l <= ld_left;
        stage_r <= ld_right;
      end
      if (fall) begin
        lr_last <= lrck;
        armed   <= 1'b1;
        if (lr_edge) begin
          if (start_left) hold_r <= stage_r;
          if (!fmt_i2s) begin
            sdata <= word[W-1];
            sh    <= {word[W-2:0], 1'b0};
            rem   <= CW'(W - 1);
          end else begin
            sdata <= 1'b0;
            sh    <= word;
            rem   <= CW'(W);
          end
        end else if (rem != '0) begin
          sdata <= sh[W-1];
          sh    <= {sh[W-2:0], 1'b0};
          rem   <= rem - 1'b1;
        end else begin
          sdata <= 1'b0;
        end
      end
    end
  end

  assert_out_only_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdata));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !lr_edge && rem == '0) |=> (sdata == 1'b0));

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CW'(W));

  assert_lj_msb_at_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_edge && !fmt_i2s) |=> (sdata == $past(word[W-1])));

  assert_i2s_empty_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_edge && fmt_i2s) |=> (sdata == 1'b0 && rem == CW'(W)));
endmodule

// File: tb/dual_fmt_audio_tx_bench.sv
module dual_fmt_audio_tx_bench;
  logic clk = 0, rst_n = 0, bclk = 1, lrck = 0, fmt_i2s = 0, ld_stb = 0;
  logic [17:0] ld_left = '0, ld_right = '0;
  logic sdata;
  int vectors = 0, miscompares = 0;
  logic [17:0] m_stage_l = '0, m_stage_r = '0;
  bit   exp_q[$];
  string tag_q[$];
  logic last_rise_val = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_fmt_audio_tx u_dual_fmt_audio_tx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .fmt_i2s(fmt_i2s),
    .ld_stb(ld_stb), .ld_left(ld_left), .ld_right(ld_right), .sdata(sdata));

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: sdata=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge bclk) begin
    if (exp_q.size() > 0) begin
      check(sdata, exp_q.pop_front(), tag_q.pop_front());
      last_rise_val = sdata;
    end
  end

  always @(negedge bclk) begin
    if (rst_n && vectors > 0) check(sdata, last_rise_val, "R6");
  end

  task automatic half(input logic lvl, input int n, input logic [17:0] w,
                      input int mid, input logic [17:0] nl, input logic [17:0] nr,
                      input bit quiet, input string tag);
    for (int k = 0; k < n; k++) begin
      bit e;
      string t;
      if (quiet) begin e = 0; t = "R9"; end
      else if (!fmt_i2s) begin
        e = (k < 18) ? w[17-k] : 1'b0;
        t = (k == 0) ? "R2" : (k < 18) ? tag : (n != 32 ? "R8" : "R5");
      end else begin
        e = (k >= 1 && k <= 18) ? w[18-k] : 1'b0;
        t = (k <= 1) ? "R3" : (k <= 18) ? tag : (n != 32 ? "R8" : "R5");
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bclk = 0;
      if (k == 0) lrck = lvl;
      if (k == mid) begin
        ld_left = nl; ld_right = nr; ld_stb = 1;
        m_stage_l = nl; m_stage_r = nr;
      end
      @(negedge clk);
      ld_stb = 0;
      repeat (3) @(negedge clk);
      bclk = 1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic frame(input int n, input int mid, input logic [17:0] nl,
                       input logic [17:0] nr, input string tl, input string tr);
    logic [17:0] hl, hr;
    logic left_lvl;
    hl = m_stage_l; hr = m_stage_r;
    left_lvl = fmt_i2s ? 1'b0 : 1'b1;
    half(left_lvl, n, hl, mid, nl, nr, 0, tl);
    half(~left_lvl, n, hr, -1, '0, '0, 0, tr);
  endtask

  task automatic run_format(input logic f);
    rst_n = 0;
    bclk = 1;
    fmt_i2s = f;
    lrck = f ? 1'b1 : 1'b0;
    m_stage_l = '0; m_stage_r = '0;
    repeat (4) @(negedge clk);
    check(sdata, 1'b0, "R9");
    rst_n = 1;
    repeat (2) @(negedge clk);
    half(lrck, 32, '0, 5, 18'h2A5C3, 18'h15A3C, 1, "R9");
    frame(32, 9, 18'h3FFFF, 18'h00001, "R7", "R7");
    frame(32, -1, '0, '0, "R4", "R4");
    frame(24, 3, 18'h20001, 18'h1B6D9, "R1", "R4");
    frame(40, -1, '0, '0, "R8", "R8");
    frame(32, -1, '0, '0, "R1", "R1");
  endtask

  initial begin
    run_format(1'b0);
    run_format(1'b1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule